// File: doc/BRIEF.md
# Debug Trace Mode Controller

This block is the control unit of a debug port. It holds a small configuration register and uses it to decide what an external event-in pin does. One mode turns a rising edge on the pin into synchronisation requests for the program-trace and data-trace message streams. Each request stays pending until the matching formatter acknowledges it. Another mode turns the pin level into a breakpoint request. The remaining two settings leave the pin without effect. The same register drives three trace-type enables: branch, data and ownership.

A second pair of bits controls development access: debug enable and debug-on-reset. These bits can only be written while system reset is asserted. A write outside that window is dropped and sets a sticky error flag. When both bits are set, the block issues a single-cycle halt request on the first clock after system reset is released. The message formatter and the processor core are outside the block. Acknowledge inputs and request outputs connect to them.

Top module: `trace_dbg_ctrl`

## Requirements
- R1: After the module reset `rst_n` is low, all trace enables, both pending-sync flags, `brk_req`, `dbg_en`, `halt_on_exit`, `halt_pulse` and `lock_err` read 0. The event control field is 00.
- R2: A write with `wr_addr`=0 loads the configuration. `wr_data[4]` enables branch trace, `wr_data[3]` enables data trace and `wr_data[2]` enables ownership trace. `wr_data[1:0]` is the event control field. Any combination of enables may be set, and the new values appear after the write clock edge.
- R3: With event control 00, a rising edge on `evt_in` sets `pgm_sync_pend` only if branch trace is enabled, and sets `dat_sync_pend` only if data trace is enabled. The flags rise three clock edges after `evt_in` rises, because the pin passes through a two-stage synchroniser.
- R4: A one-cycle `pgm_ack` or `dat_ack` clears its own flag at the next edge. If a new edge arrives in the same cycle as the acknowledge, the flag stays set.
- R5: With event control 01, `brk_req` is high two clock edges after `evt_in` rises. It stays high for as long as `evt_in` is held, and it does not set the sync flags.
- R6: With event control 10 or 11, `evt_in` sets no sync flag and raises no breakpoint request.
- R7: A write with `wr_addr`=1 while `sys_rst`=1 loads `dbg_en` from `wr_data[0]` and debug-on-reset from `wr_data[1]`.
- R8: A write with `wr_addr`=1 while `sys_rst`=0 leaves both debug bits unchanged and sets `lock_err`. `lock_err` then stays set until `rst_n` is asserted.
- R9: `halt_on_exit` is 1 only when debug enable and debug-on-reset are both 1. With `dbg_en`=0 it is 0 whatever debug-on-reset holds.
- R10: `halt_pulse` is high for exactly one cycle, on the first clock edge at which `sys_rst` is sampled low after being high, and only when `halt_on_exit` is 1.
- R11: Asserting `rst_n` returns both debug bits and `lock_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Debug module reset, active low |
| sys_rst | input | 1 | System reset, active high; opens the debug-bit write window |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: trace configuration, 1: debug access bits |
| wr_data | input | 5 | Write data |
| evt_in | input | 1 | Asynchronous event-in pin |
| pgm_ack | input | 1 | Program-trace formatter sent a sync message |
| dat_ack | input | 1 | Data-trace formatter sent a sync message |
| trc_branch_en | output | 1 | Branch trace enable |
| trc_data_en | output | 1 | Data trace enable |
| trc_own_en | output | 1 | Ownership trace enable |
| pgm_sync_pend | output | 1 | Next program-trace message must be a sync message |
| dat_sync_pend | output | 1 | Next data-trace message must be a sync message |
| brk_req | output | 1 | Level breakpoint request |
| dbg_en | output | 1 | Debug mode enabled |
| halt_on_exit | output | 1 | Debug mode is entered as reset is released |
| halt_pulse | output | 1 | One-cycle halt request after system reset release |
| lock_err | output | 1 | Sticky: debug bits were written outside system reset |

## Verification
The hardest case to reach is a new synchronised edge that lands in the same cycle as a formatter acknowledge. The bench first leaves a flag set by an earlier event and drops the pin low. It then raises the pin again and, counting the two synchroniser stages, drives the acknowledge in the exact cycle that the edge detector fires. The halt pulse also needs a precise sequence: system reset is held, the locked bits are written inside the window, and the pulse is sampled on the first and second cycles after release.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    localparam int TM_W  = 3;
    localparam int EC_W  = 2;
    localparam int CFG_W = TM_W + EC_W;

    localparam logic [EC_W-1:0] EC_SYNC = 2'b00;
    localparam logic [EC_W-1:0] EC_BRK  = 2'b01;

    // trace-mode bit positions inside tm
    localparam int TM_BRANCH = 2;
    localparam int TM_DATA   = 1;
    localparam int TM_OWN    = 0;

    typedef struct packed {
        logic [TM_W-1:0] tm;
        logic [EC_W-1:0] ec;
    } cfg_t;

    typedef struct packed {
        logic dbg_en;
        logic dbg_on_rst;
        logic sys_rst_prev;
        logic halt_pulse;
        logic lock_err;
    } acc_t;
endpackage

// File: rtl/tdc_evt_sync.sv
module tdc_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic level,
    output logic rise
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], evt_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tdc_pend_flag.sv
module tdc_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic pend
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = set | (pend_q & ~ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/tdc_access_lock.sv
module tdc_access_lock
    import tdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_rst,
    input  logic       acc_wr,
    input  logic [1:0] acc_data,
    output logic       dbg_en,
    output logic       dbg_on_rst,
    output logic       halt_pulse,
    output logic       lock_err
);
    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sys_rst_prev = sys_rst;
        if (acc_wr) begin
            if (sys_rst) begin
                st_d.dbg_en     = acc_data[0];
                st_d.dbg_on_rst = acc_data[1];
            end else begin
                st_d.lock_err = 1'b1;
            end
        end
        st_d.halt_pulse = st_q.sys_rst_prev & ~sys_rst
                        & st_q.dbg_en & st_q.dbg_on_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dbg_en     = st_q.dbg_en;
    assign dbg_on_rst = st_q.dbg_on_rst;
    assign halt_pulse = st_q.halt_pulse;
    assign lock_err   = st_q.lock_err;
endmodule

// File: rtl/trace_dbg_ctrl.sv
module trace_dbg_ctrl
    import tdc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             evt_in,
    input  logic             pgm_ack,
    input  logic             dat_ack,
    output logic             trc_branch_en,
    output logic             trc_data_en,
    output logic             trc_own_en,
    output logic             pgm_sync_pend,
    output logic             dat_sync_pend,
    output logic             brk_req,
    output logic             dbg_en,
    output logic             halt_on_exit,
    output logic             halt_pulse,
    output logic             lock_err
);
    localparam int N_KIND = 2;   // 0: program trace, 1: data trace

    cfg_t cfg_d, cfg_q;
    logic evt_level, evt_rise;
    logic dbg_on_rst;
    logic [N_KIND-1:0] kind_en, kind_ack, kind_set, kind_pend;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && !wr_addr) cfg_d = cfg_t'(wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    tdc_evt_sync #(.STAGES(SYNC_STAGES)) evt_sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (evt_in),
        .level  (evt_level),
        .rise   (evt_rise)
    );

    assign kind_en  = {cfg_q.tm[TM_DATA], cfg_q.tm[TM_BRANCH]};
    assign kind_ack = {dat_ack, pgm_ack};

    generate
        for (genvar k = 0; k < N_KIND; k++) begin : g_kind
            assign kind_set[k] = evt_rise & (cfg_q.ec == EC_SYNC) & kind_en[k];
            tdc_pend_flag flag_i (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (kind_set[k]),
                .ack   (kind_ack[k]),
                .pend  (kind_pend[k])
            );
        end
    endgenerate

    tdc_access_lock acc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_rst    (sys_rst),
        .acc_wr     (wr_en & wr_addr),
        .acc_data   (wr_data[1:0]),
        .dbg_en     (dbg_en),
        .dbg_on_rst (dbg_on_rst),
        .halt_pulse (halt_pulse),
        .lock_err   (lock_err)
    );

    assign trc_branch_en = cfg_q.tm[TM_BRANCH];
    assign trc_data_en   = cfg_q.tm[TM_DATA];
    assign trc_own_en    = cfg_q.tm[TM_OWN];
    assign pgm_sync_pend = kind_pend[0];
    assign dat_sync_pend = kind_pend[1];
    assign brk_req       = evt_level & (cfg_q.ec == EC_BRK);
    assign halt_on_exit  = dbg_en & dbg_on_rst;
endmodule

// File: rtl/trace_dbg_ctrl_chk.sv
module trace_dbg_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_rst,
    input logic [1:0] ec,
    input logic       pgm_sync_pend,
    input logic       dat_sync_pend,
    input logic       brk_req,
    input logic       dbg_en,
    input logic       halt_on_exit,
    input logic       halt_pulse,
    input logic       lock_err
);
    // R5: breakpoint request only in breakpoint mode
    assert_brk_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> ec == 2'b01);

    // R6: reserved codes never request a breakpoint
    assert_reserved_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ec[1] |-> !brk_req);

    // R3: sync flags only rise out of sync mode
    assert_pgm_sync_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgm_sync_pend) |-> $past(ec) == 2'b00);
    assert_dat_sync_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_sync_pend) |-> $past(ec) == 2'b00);

    // R7: debug bits frozen outside system reset
    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst |=> $stable(dbg_en));

    // R8: error flag is sticky
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |=> lock_err);

    // R9: halt pulse only when halting on exit
    assert_halt_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |-> halt_on_exit);

    // R10: halt pulse lasts one cycle, outside system reset
    assert_halt_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |=> !halt_pulse);
    assert_halt_after_rst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |-> !sys_rst);
endmodule

bind trace_dbg_ctrl trace_dbg_ctrl_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sys_rst       (sys_rst),
    .ec            (cfg_q.ec),
    .pgm_sync_pend (pgm_sync_pend),
    .dat_sync_pend (dat_sync_pend),
    .brk_req       (brk_req),
    .dbg_en        (dbg_en),
    .halt_on_exit  (halt_on_exit),
    .halt_pulse    (halt_pulse),
    .lock_err      (lock_err)
);

// File: tb/trace_dbg_ctrl_tb_top.sv
`timescale 1ns/1ps
module trace_dbg_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_rst = 1'b0;
    logic wr_en = 1'b0;
    logic wr_addr = 1'b0;
    logic [4:0] wr_data = '0;
    logic evt_in = 1'b0;
    logic pgm_ack = 1'b0;
    logic dat_ack = 1'b0;
    logic trc_branch_en, trc_data_en, trc_own_en;
    logic pgm_sync_pend, dat_sync_pend, brk_req;
    logic dbg_en, halt_on_exit, halt_pulse, lock_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trace_dbg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .evt_in(evt_in),
        .pgm_ack(pgm_ack), .dat_ack(dat_ack),
        .trc_branch_en(trc_branch_en), .trc_data_en(trc_data_en),
        .trc_own_en(trc_own_en), .pgm_sync_pend(pgm_sync_pend),
        .dat_sync_pend(dat_sync_pend), .brk_req(brk_req), .dbg_en(dbg_en),
        .halt_on_exit(halt_on_exit), .halt_pulse(halt_pulse),
        .lock_err(lock_err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [4:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic module_reset();
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
    endtask

    task automatic clear_flags();
        pgm_ack = 1'b1; dat_ack = 1'b1; tick(1);
        pgm_ack = 1'b0; dat_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 tm", {5'd0, trc_branch_en, trc_data_en, trc_own_en}, 8'd0);
        chk("R1 flags", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'd0);
        chk("R1 brk", {7'd0, brk_req}, 8'd0);
        chk("R1 access", {4'd0, dbg_en, halt_on_exit, halt_pulse, lock_err}, 8'd0);
    endtask

    task automatic t_trace_mode();
        wr(1'b0, 5'b101_00);
        chk("R2 tm=101", {5'd0, trc_branch_en, trc_data_en, trc_own_en}, 8'b101);
        wr(1'b0, 5'b010_00);
        chk("R2 tm=010", {5'd0, trc_branch_en, trc_data_en, trc_own_en}, 8'b010);
        wr(1'b0, 5'b111_00);
        chk("R2 tm=111", {5'd0, trc_branch_en, trc_data_en, trc_own_en}, 8'b111);
    endtask

    task automatic t_sync_both();
        wr(1'b0, 5'b110_00);
        evt_in = 1'b1; tick(1); evt_in = 1'b0; tick(1);
        chk("R3 not yet", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b00);
        tick(1);
        chk("R3 both set", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b11);
        tick(3);
        chk("R3 held", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b11);
        pgm_ack = 1'b1; tick(1); pgm_ack = 1'b0;
        chk("R4 pgm ack", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b01);
        dat_ack = 1'b1; tick(1); dat_ack = 1'b0;
        chk("R4 dat ack", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b00);
    endtask

    task automatic t_sync_masked();
        wr(1'b0, 5'b011_00);
        evt_in = 1'b1; tick(1); evt_in = 1'b0; tick(4);
        chk("R3 data only", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b01);
        clear_flags();
        wr(1'b0, 5'b100_00);
        evt_in = 1'b1; tick(1); evt_in = 1'b0; tick(4);
        chk("R3 branch only", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b10);
        clear_flags();
    endtask

    task automatic t_ack_collide();
        wr(1'b0, 5'b110_00);
        evt_in = 1'b1; tick(1); evt_in = 1'b0; tick(4);
        chk("R4 pre", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b11);
        evt_in = 1'b1; tick(2);
        pgm_ack = 1'b1; dat_ack = 1'b1; tick(1);
        pgm_ack = 1'b0; dat_ack = 1'b0; evt_in = 1'b0;
        chk("R4 collide keeps", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b11);
        tick(2);
        chk("R4 still set", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b11);
        clear_flags();
    endtask

    task automatic t_brk();
        wr(1'b0, 5'b111_01);
        evt_in = 1'b1; tick(1);
        chk("R5 not yet", {7'd0, brk_req}, 8'd0);
        tick(1);
        chk("R5 brk on", {7'd0, brk_req}, 8'd1);
        tick(6);
        chk("R5 brk held", {7'd0, brk_req}, 8'd1);
        chk("R5 no sync", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b00);
        evt_in = 1'b0; tick(2);
        chk("R5 brk off", {7'd0, brk_req}, 8'd0);
    endtask

    task automatic t_no_action();
        for (int c = 2; c < 4; c++) begin
            wr(1'b0, {3'b111, 2'(c)});
            evt_in = 1'b1; tick(4);
            chk("R6 brk", {7'd0, brk_req}, 8'd0);
            evt_in = 1'b0; tick(3);
            chk("R6 sync", {6'd0, pgm_sync_pend, dat_sync_pend}, 8'b00);
        end
    endtask

    task automatic t_lock();
        wr(1'b1, 5'b000_11);
        chk("R8 ignored", {6'd0, dbg_en, halt_on_exit}, 8'b00);
        chk("R8 err set", {7'd0, lock_err}, 8'd1);
        tick(3);
        chk("R8 err sticky", {7'd0, lock_err}, 8'd1);
    endtask

    task automatic t_access();
        sys_rst = 1'b1; tick(1);
        wr(1'b1, 5'b000_01);
        chk("R7 dbg_en", {7'd0, dbg_en}, 8'd1);
        chk("R9 run mode", {7'd0, halt_on_exit}, 8'd0);
        sys_rst = 1'b0; tick(1);
        chk("R10 no pulse", {7'd0, halt_pulse}, 8'd0);
        sys_rst = 1'b1; tick(1);
        wr(1'b1, 5'b000_10);
        chk("R9 non-debug", {6'd0, dbg_en, halt_on_exit}, 8'b00);
        wr(1'b1, 5'b000_11);
        chk("R9 halt mode", {6'd0, dbg_en, halt_on_exit}, 8'b11);
        chk("R10 none in reset", {7'd0, halt_pulse}, 8'd0);
        sys_rst = 1'b0; tick(1);
        chk("R10 pulse", {7'd0, halt_pulse}, 8'd1);
        tick(1);
        chk("R10 pulse ends", {7'd0, halt_pulse}, 8'd0);
    endtask

    task automatic t_mod_reset();
        module_reset();
        chk("R11 bits", {5'd0, dbg_en, halt_on_exit, lock_err}, 8'd0);
        chk("R1 tm after reset", {5'd0, trc_branch_en, trc_data_en, trc_own_en}, 8'd0);
    endtask

    initial begin
        tick(1);
        t_reset();
        rst_n = 1'b1; tick(1);
        t_reset();
        t_trace_mode();
        t_sync_both();
        t_sync_masked();
        t_ack_collide();
        t_brk();
        t_no_action();
        t_lock();
        t_access();
        t_mod_reset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(20000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule